// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit sits beside a processor core and counts hardware events on six 32-bit up-counters. Each counter picks one event strobe from a per-cycle event bus through an event code held in one of two control words, and adds one for each cycle in which that strobe is high. Counting can be stopped globally, in supervisor or in user privilege, or according to the level of a mark input, and each of these stops acts on its own.

Software preloads a counter with 0x80000000 minus N so that its top bit comes on after N events. A counter whose top bit is set and whose overflow enable is on raises the interrupt request when the interrupt enable is on. On the cycle the request rises, the unit captures the current instruction address into a sampled-address register. If freeze-on-exception is on, it also sets the global freeze bit so that the counts stop for the handler to read. A plain register port with a combinational read path reaches the counters, both control words and the sampled address. The port has no handshake: a write takes effect at the clock edge where `reg_we` is high.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every counter, both control words and the sampled address read as zero, and `irq_o` is low.
- R2: Register addresses: 0 to 5 are counters 1 to 6, 6 is control word A, 7 is control word B, and 8 is the sampled address, which is read-only. Writes to 8 have no effect, and addresses 9 and above read zero.
- R3: Event code fields: counter 1 is A[12:6], counter 2 is A[5:0], counter 3 is B[31:27], counter 4 is B[26:22], counter 5 is B[21:17] and counter 6 is B[16:11]. Code c selects `evt_i[c]`. A code of 0, or a code of NUM_EVT or more, never counts.
- R4: A counter that is not frozen and not written goes up by exactly one at each clock edge where its selected strobe is high. Otherwise it holds its value.
- R5: While A[31] (global freeze) is 1, no counter increments.
- R6: A[30] stops counting while `supv_i` is 1 (supervisor), and A[29] stops counting while `supv_i` is 0 (user).
- R7: A[28] stops counting while `mark_i` is 1, and A[27] stops counting while `mark_i` is 0.
- R8: A register write to a counter wins over that counter's increment in the same cycle. The counter then holds exactly the written value.
- R9: `irq_o` is high exactly when A[26] is 1 and some counter has bit 31 set with its overflow enable on. The enable is A[15] for counter 1 and A[14] for counters 2 to 6.
- R10: At the clock edge that ends the first cycle of `irq_o` high (after a cycle with it low), the sampled-address register loads `pc_i`.
- R11: At that same edge, if A[25] is 1, A[31] becomes 1. A register write to A in that cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Per-cycle event strobes |
| supv_i | input | 1 | 1 while the core runs in supervisor privilege |
| mark_i | input | 1 | Mark bit from the core |
| pc_i | input | 32 | Current instruction address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two functions can land in the same cycle: a software write to a counter or to control word A, and the hardware action aimed at the same register. For a counter that action is an increment. For A it is the global-freeze set made by freeze-on-exception. Directed cases drive a counter write while its event strobe is high. The random phase preloads counters just below 0x80000000 and writes A at random times, so the rising edge of the interrupt often coincides with a write to A. A bench model that gives the write priority judges every cycle through the read port and `irq_o`.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_CTR = 6;
  localparam int CODE_W  = 7;

  // control word A bit positions
  localparam int A_FRZ_ALL  = 31;
  localparam int A_FRZ_SUPV = 30;
  localparam int A_FRZ_USER = 29;
  localparam int A_FRZ_MK1  = 28;
  localparam int A_FRZ_MK0  = 27;
  localparam int A_IRQ_EN   = 26;
  localparam int A_FRZ_EXC  = 25;
  localparam int A_OVF_EN1  = 15;
  localparam int A_OVF_ENN  = 14;

  localparam int ADR_CTL_A = 6;
  localparam int ADR_CTL_B = 7;
  localparam int ADR_SAMP  = 8;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/pmu_freeze.sv
module pmu_freeze
  import pmu_pkg::*;
(
  input  word_t ctl_a,
  input  logic  supv_i,
  input  logic  mark_i,
  output logic  freeze_o
);
  always_comb begin
    freeze_o = ctl_a[A_FRZ_ALL]
             | (ctl_a[A_FRZ_SUPV] &  supv_i)
             | (ctl_a[A_FRZ_USER] & ~supv_i)
             | (ctl_a[A_FRZ_MK1]  &  mark_i)
             | (ctl_a[A_FRZ_MK0]  & ~mark_i);
  end
endmodule

// File: rtl/pmu_ctr.sv
module pmu_ctr
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  word_t              wdata,
  input  logic [NUM_EVT-1:0] evt_i,
  input  code_t              code,
  input  logic               freeze_i,
  output word_t              cnt_o
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  word_t            code_ext;
  logic [IDX_W-1:0] idx;
  logic             hit;
  word_t            cnt_q;

  always_comb begin
    code_ext = word_t'(code);
    idx      = code_ext[IDX_W-1:0];
    hit      = (code != '0) && (code_ext < word_t'(NUM_EVT)) && evt_i[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (wr_en)            cnt_q <= wdata;
    else if (hit && !freeze_i) cnt_q <= cnt_q + word_t'(1);
  end

  assign cnt_o = cnt_q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + word_t'(1)));
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze_i) && !$past(wr_en)) |-> (cnt_q == $past(cnt_q)));
  assert_wr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (cnt_q == $past(wdata)));
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 64,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               supv_i,
  input  logic               mark_i,
  input  logic [31:0]        pc_i,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_o
);
  word_t              ctl_a, ctl_b, samp_q;
  logic               irq_q, freeze, take;
  code_t              code [NUM_CTR];
  word_t              cnt  [NUM_CTR];
  logic [NUM_CTR-1:0] ovf;

  always_comb begin
    code[0] = ctl_a[12:6];
    code[1] = {1'b0,  ctl_a[5:0]};
    code[2] = {2'b00, ctl_b[31:27]};
    code[3] = {2'b00, ctl_b[26:22]};
    code[4] = {2'b00, ctl_b[21:17]};
    code[5] = {1'b0,  ctl_b[16:11]};
  end

  pmu_freeze u_freeze (
    .ctl_a(ctl_a), .supv_i(supv_i), .mark_i(mark_i), .freeze_o(freeze)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    pmu_ctr #(.NUM_EVT(NUM_EVT)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && (reg_addr == ADDR_W'(g))),
      .wdata(reg_wdata), .evt_i(evt_i), .code(code[g]),
      .freeze_i(freeze), .cnt_o(cnt[g])
    );
    if (g == 0) begin : g_en1
      assign ovf[g] = cnt[g][DATA_W-1] & ctl_a[A_OVF_EN1];
    end else begin : g_enn
      assign ovf[g] = cnt[g][DATA_W-1] & ctl_a[A_OVF_ENN];
    end
  end

  assign irq_o = ctl_a[A_IRQ_EN] & (|ovf);
  assign take  = irq_o & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a  <= '0;
      ctl_b  <= '0;
      samp_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_o;
      if (take) samp_q <= pc_i;
      if (reg_we && reg_addr == ADDR_W'(ADR_CTL_A)) ctl_a <= reg_wdata;
      else if (take && ctl_a[A_FRZ_EXC])             ctl_a[A_FRZ_ALL] <= 1'b1;
      if (reg_we && reg_addr == ADDR_W'(ADR_CTL_B)) ctl_b <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = cnt[i];
    if (reg_addr == ADDR_W'(ADR_CTL_A)) reg_rdata = ctl_a;
    if (reg_addr == ADDR_W'(ADR_CTL_B)) reg_rdata = ctl_b;
    if (reg_addr == ADDR_W'(ADR_SAMP))  reg_rdata = samp_q;
  end

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctl_a[A_IRQ_EN]);
  assert_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_q) |=> (samp_q == $past(pc_i)));
  assert_exc_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_q && ctl_a[A_FRZ_EXC] && !(reg_we && reg_addr == ADDR_W'(ADR_CTL_A)))
      |=> ctl_a[A_FRZ_ALL]);
endmodule

// File: tb/pmu_counter_unit_test.sv
`timescale 1ns/1ps
module pmu_counter_unit_test;
  localparam int NE = 64;

  logic clk = 0, rst_n = 0;
  logic [NE-1:0] evt = '0;
  logic supv = 0, mark = 0, we = 0;
  logic [31:0] pc = '0, wdata = '0;
  logic [3:0] addr = '0;
  logic [31:0] rdata;
  logic irq;
  int errors = 0, checks = 0;

  pmu_counter_unit #(.NUM_EVT(NE), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .supv_i(supv), .mark_i(mark),
    .pc_i(pc), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  logic [31:0] m_cnt [6];
  logic [31:0] m_a, m_b, m_s;
  logic m_iq;

  function automatic int code_of(int i);
    case (i)
      0: return int'(m_a[12:6]);
      1: return int'(m_a[5:0]);
      2: return int'(m_b[31:27]);
      3: return int'(m_b[26:22]);
      4: return int'(m_b[21:17]);
      default: return int'(m_b[16:11]);
    endcase
  endfunction

  function automatic logic m_irq();
    logic any = 0;
    for (int i = 0; i < 6; i++)
      if (m_cnt[i][31] && (i == 0 ? m_a[15] : m_a[14])) any = 1;
    return m_a[26] & any;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a < 6) return m_cnt[a];
    if (a == 6) return m_a;
    if (a == 7) return m_b;
    if (a == 8) return m_s;
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic w, int a, logic [31:0] d,
                      logic [NE-1:0] e, logic s, logic m, logic [31:0] p);
    logic fr, ir, tk;
    logic [31:0] n_cnt [6];
    logic [31:0] n_a;
    @(negedge clk);
    we = w; addr = 4'(a); wdata = d; evt = e; supv = s; mark = m; pc = p;
    #1;
    chk("R9 irq", {31'b0, irq}, {31'b0, m_irq()});
    if (!w) chk(tag, rdata, m_read(a));
    fr = m_a[31] | (m_a[30] & s) | (m_a[29] & ~s) | (m_a[28] & m) | (m_a[27] & ~m);
    ir = m_irq();
    tk = ir & ~m_iq;
    for (int i = 0; i < 6; i++) begin
      int c = code_of(i);
      n_cnt[i] = m_cnt[i];
      if (w && a == i) n_cnt[i] = d;
      else if (!fr && c != 0 && c < NE && e[c]) n_cnt[i] = m_cnt[i] + 1;
    end
    n_a = m_a;
    if (w && a == 6) n_a = d;
    else if (tk && m_a[25]) n_a[31] = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 6; i++) m_cnt[i] = n_cnt[i];
    if (tk) m_s = p;
    if (w && a == 7) m_b = d;
    m_a = n_a;
    m_iq = ir;
  endtask

  task automatic wr(int a, logic [31:0] d);
    step("R2 write", 1, a, d, '0, 0, 0, 32'h0);
  endtask

  task automatic rd(string tag, int a);
    step(tag, 0, a, 32'h0, '0, 0, 0, 32'h0);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NE-1:0] e5;
    void'($urandom(32'd4242));
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    m_a = 0; m_b = 0; m_s = 0; m_iq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 10; a++) rd("R1 reset", a);
    chk("R1 irq low", {31'b0, irq}, 32'h0);

    // R3 counter 3 code 5 in B[31:27]
    e5 = '0; e5[5] = 1'b1;
    wr(7, 32'd5 << 27);
    repeat (4) step("R3 count", 0, 2, 32'h0, e5, 0, 0, 32'h0);
    rd("R3 ctr3", 2);
    chk("R3 ctr3 value", rdata, 32'd4);
    // R3 out-of-range code on counter 1
    wr(6, 32'd100 << 6);
    repeat (3) step("R3 bad code", 0, 0, 32'h0, '1, 0, 0, 32'h0);
    chk("R3 bad code holds", rdata, 32'd0);
    // R4 counter 1 code 3
    wr(6, 32'd3 << 6);
    repeat (3) step("R4 count", 0, 0, 32'h0, '1, 0, 0, 32'h0);
    rd("R4 ctr1", 0);
    chk("R4 ctr1 value", rdata, 32'd3);
    // R5 global freeze
    wr(6, (32'd3 << 6) | (32'd1 << 31));
    repeat (3) step("R5 frozen", 0, 0, 32'h0, '1, 0, 0, 32'h0);
    chk("R5 frozen value", rdata, 32'd3);
    // R6 supervisor freeze
    wr(6, (32'd3 << 6) | (32'd1 << 30));
    repeat (2) step("R6 supv", 0, 0, 32'h0, '1, 1, 0, 32'h0);
    repeat (2) step("R6 user", 0, 0, 32'h0, '1, 0, 0, 32'h0);
    rd("R6 ctr1", 0);
    chk("R6 value", rdata, 32'd5);
    // R7 mark-set freeze
    wr(6, (32'd3 << 6) | (32'd1 << 28));
    repeat (2) step("R7 mark1", 0, 0, 32'h0, '1, 0, 1, 32'h0);
    repeat (1) step("R7 mark0", 0, 0, 32'h0, '1, 0, 0, 32'h0);
    rd("R7 ctr1", 0);
    chk("R7 value", rdata, 32'd6);
    // R8 write beats increment
    wr(6, 32'd3 << 6);
    step("R8 collide", 1, 0, 32'h1234, '1, 0, 0, 32'h0);
    rd("R8 ctr1", 0);
    chk("R8 value", rdata, 32'h1234);
    // R2 write to sampled address ignored
    wr(8, 32'hDEAD);
    rd("R2 samp ro", 8);
    chk("R2 samp ro value", rdata, 32'h0);
    // R9/R10/R11 overflow path
    wr(0, 32'h7FFF_FFFE);
    wr(6, (32'd3 << 6) | (32'd1 << 26) | (32'd1 << 25) | (32'd1 << 15));
    step("R9 pre", 0, 0, 32'h0, '1, 0, 0, 32'h100);
    step("R9 edge", 0, 0, 32'h0, '1, 0, 0, 32'h104);
    step("R10 take", 0, 8, 32'h0, '0, 0, 0, 32'hABCD_0000);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    rd("R10 samp", 8);
    chk("R10 samp value", rdata, 32'hABCD_0000);
    rd("R11 ctl a", 6);
    chk("R11 freeze set", {31'b0, rdata[31]}, 32'h1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic w;
      int a;
      logic [31:0] d;
      w = ($urandom % 4) == 0;
      a = $urandom % 10;
      d = $urandom;
      if (a < 6 && ($urandom % 2)) d = 32'h7FFF_FFF0 + ($urandom % 16);
      if (a == 6 && ($urandom % 4) != 0) d[31] = 1'b0;
      step(a < 6 ? "R4 rand ctr" : (a == 8 ? "R10 rand samp" : "R2 rand reg"),
           w, a, d, {$urandom, $urandom}, 1'($urandom), 1'($urandom), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule